// File: doc/BRIEF.md
# Conflict-Free Buffer Bank Selector

This block sits beside the pool of parallel, single-ported buffer memories in a shared-memory cell switch with N ports. Each output keeps a first-come-first-served queue. For every arriving fixed-size cell it is given the cell's destination output. It works out the time slot in which that cell must leave, then names the memory the cell should be written into. The chosen memory is free to accept the write now and is also free to be read in the departure slot. A cell that has to leave before a memory access could complete is flagged to skip the memories and go straight to its output.

Time runs in decision slots, one per clock cycle, and N decision slots make one time slot. A write occupies a memory for `BUSY` decision slots. A read is booked against a whole time slot. Future reads are held in a table of k-bit masks, indexed by departure slot modulo `HORIZON`, and each entry is cleared as its slot ends. Among the eligible memories the lowest-numbered one is taken. Each request gets its answer one cycle later.

Top module: `bank_selector`

## Requirements
- R1: While `rst` is high and on the first cycle after it falls, `grant_valid`, `grant_bypass` and `grant_err` are 0.
- R2: A request sampled with `req_valid` high at a rising edge produces exactly one result, with `grant_valid` high, registered at that edge. A cycle with `req_valid` low produces `grant_valid` low at the next edge.
- R3: Decision slots advance once per clock after reset. The time slot starts at 0 and goes up by one after every N decision slots.
- R4: A cell's departure slot `grant_dep` is one more than the larger of two values: the last departure slot given to the same output (0 after reset), and the current time slot. Departure slots of different outputs are independent.
- R5: When the departure slot is less than the current slot plus `ACC_SLOTS`, `grant_bypass` is 1 and `grant_mem` is 0. No memory is occupied and no read is booked.
- R6: A memory chosen at decision slot c is not chosen again before decision slot c+`BUSY`.
- R7: A memory booked to read in the current time slot is not chosen.
- R8: A memory already booked to read in the cell's departure slot is not chosen. A successful choice books it there.
- R9: Among the memories that pass R6 to R8, the lowest-numbered one is chosen.
- R10: If the departure slot minus the current slot is `HORIZON` or more, or if no memory is eligible, `grant_err` is 1. Nothing is committed: the output's last departure slot, the bookings and the write state are unchanged.
- R11: A booking is released when its time slot ends. A memory booked for slot t is therefore eligible again for slot t+`HORIZON`.
- R12: With K at least 2N+`BUSY`-1 and every departure within `HORIZON` slots, no request is refused for lack of an eligible memory.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, one decision slot per cycle |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | A cell arrives in this decision slot |
| req_port | input | $clog2(N) | Destination output of the arriving cell |
| grant_valid | output | 1 | Result for last cycle's request |
| grant_mem | output | $clog2(K) | Chosen memory index |
| grant_dep | output | TW | Departure time slot of the cell |
| grant_bypass | output | 1 | Cell skips the memories |
| grant_err | output | 1 | No choice could be made; nothing committed |

## Verification
The assertions assume that at most one cell arrives per decision slot and that the time-slot counter does not wrap within a run. They also assume `BUSY` is at least 2, which is what makes it illegal for the same memory to be chosen twice in a row. The stimulus drives one request or an idle per cycle through a single task. Each run stays far below the counter width. The mixed and long-running patterns keep every output's backlog under `HORIZON`, and only the dedicated overload scenario pushes one output past that limit on purpose.

// File: rtl/bank_selector.sv
module bank_selector #(
  parameter int N         = 4,
  parameter int K         = 12,
  parameter int BUSY      = 3,
  parameter int ACC_SLOTS = 2,
  parameter int HORIZON   = 16,
  parameter int TW        = 16
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 req_valid,
  input  logic [$clog2(N)-1:0] req_port,
  output logic                 grant_valid,
  output logic [$clog2(K)-1:0] grant_mem,
  output logic [TW-1:0]        grant_dep,
  output logic                 grant_bypass,
  output logic                 grant_err
);
  localparam int PW = $clog2(N);
  localparam int MW = $clog2(K);
  localparam int HW = $clog2(HORIZON);
  localparam int CW = $clog2(BUSY);

  logic [PW-1:0] dslot;
  logic [TW-1:0] tslot;
  logic [TW-1:0] last_dep [N];
  logic [K-1:0]  resv [HORIZON];
  logic [CW-1:0] wcnt [K];

  logic [TW-1:0] prev, dep, span;
  logic [K-1:0]  wbusy, elig;
  logic [MW-1:0] pick;
  logic          found, too_far, bypass, fail, commit, slot_end;

  assign prev     = last_dep[req_port];
  assign dep      = ((prev > tslot) ? prev : tslot) + TW'(1);
  assign span     = dep - tslot;
  assign too_far  = span >= TW'(HORIZON);
  assign bypass   = span < TW'(ACC_SLOTS);
  assign elig     = ~wbusy & ~resv[tslot[HW-1:0]] & ~resv[dep[HW-1:0]];
  assign fail     = too_far || (!bypass && !found);
  assign commit   = req_valid && !fail && !bypass;
  assign slot_end = dslot == PW'(N - 1);

  always_comb begin
    for (int m = 0; m < K; m++) wbusy[m] = wcnt[m] != '0;
  end

  always_comb begin
    pick  = '0;
    found = 1'b0;
    for (int m = K - 1; m >= 0; m--) begin
      if (elig[m]) begin
        pick  = MW'(m);
        found = 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      dslot <= '0;
      tslot <= '0;
    end else begin
      dslot <= slot_end ? '0 : dslot + PW'(1);
      if (slot_end) tslot <= tslot + TW'(1);
    end
  end

  always_ff @(posedge clk) begin
    for (int h = 0; h < HORIZON; h++) begin
      if (rst) resv[h] <= '0;
      else if (slot_end && tslot[HW-1:0] == HW'(h)) resv[h] <= '0;
      else if (commit && dep[HW-1:0] == HW'(h)) resv[h] <= resv[h] | (K'(1) << pick);
    end
  end

  always_ff @(posedge clk) begin
    for (int m = 0; m < K; m++) begin
      if (rst) wcnt[m] <= '0;
      else if (commit && pick == MW'(m)) wcnt[m] <= CW'(BUSY - 1);
      else if (wcnt[m] != '0) wcnt[m] <= wcnt[m] - CW'(1);
    end
  end

  always_ff @(posedge clk) begin
    for (int p = 0; p < N; p++) begin
      if (rst) last_dep[p] <= '0;
      else if (req_valid && !fail && req_port == PW'(p)) last_dep[p] <= dep;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      grant_valid  <= 1'b0;
      grant_mem    <= '0;
      grant_dep    <= '0;
      grant_bypass <= 1'b0;
      grant_err    <= 1'b0;
    end else begin
      grant_valid  <= req_valid;
      grant_mem    <= (req_valid && commit) ? pick : '0;
      grant_dep    <= req_valid ? dep : '0;
      grant_bypass <= req_valid && !fail && bypass;
      grant_err    <= req_valid && fail;
    end
  end

  // R2
  no_spurious_grant_chk: assert property (@(posedge clk) disable iff (rst)
    !$past(req_valid) |-> !grant_valid);

  // R2
  flags_need_valid_chk: assert property (@(posedge clk) disable iff (rst)
    (grant_bypass || grant_err) |-> grant_valid);

  // R4
  dep_in_future_chk: assert property (@(posedge clk) disable iff (rst)
    (grant_valid && !grant_err) |-> grant_dep > $past(tslot));

  // R6
  no_back_to_back_chk: assert property (@(posedge clk) disable iff (rst)
    (grant_valid && !grant_err && !grant_bypass &&
     $past(grant_valid && !grant_err && !grant_bypass)) |-> grant_mem != $past(grant_mem));

  // R9
  mem_in_range_chk: assert property (@(posedge clk) disable iff (rst)
    grant_valid |-> int'(grant_mem) < K);

  // R5
  bypass_no_mem_chk: assert property (@(posedge clk) disable iff (rst)
    grant_bypass |-> grant_mem == '0);

  // R3
  slot_step_chk: assert property (@(posedge clk) disable iff (rst)
    $past(!rst) |-> (tslot == $past(tslot) || tslot == $past(tslot) + TW'(1)));
endmodule

// File: tb/bank_selector_test.sv
module bank_selector_test;
  localparam int N = 4, K = 12, BUSY = 3, ACC_SLOTS = 2, HORIZON = 16, TW = 16;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic req_valid = 1'b0;
  logic [$clog2(N)-1:0] req_port = '0;
  logic grant_valid, grant_bypass, grant_err;
  logic [$clog2(K)-1:0] grant_mem;
  logic [TW-1:0] grant_dep;

  bank_selector #(.N(N), .K(K), .BUSY(BUSY), .ACC_SLOTS(ACC_SLOTS),
                  .HORIZON(HORIZON), .TW(TW)) uut (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_port(req_port),
    .grant_valid(grant_valid), .grant_mem(grant_mem), .grant_dep(grant_dep),
    .grant_bypass(grant_bypass), .grant_err(grant_err));

  always #10 clk = ~clk;

  int tests = 0, fails = 0, cyc = 0, errs_seen = 0;
  int lastdep [N];
  int wlast [K];
  logic [31:0] rtab [0:255];

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst = 1'b1; req_valid = 1'b0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    // R1: reset values visible before any request
    chk(grant_valid == 0 && grant_err == 0 && grant_bypass == 0, "R1 flags after reset",
        int'({grant_valid, grant_err, grant_bypass}), 0);
    rst = 1'b0;
    cyc = 0;
    for (int p = 0; p < N; p++) lastdep[p] = 0;
    for (int m = 0; m < K; m++) wlast[m] = -100;
    for (int s = 0; s < 256; s++) rtab[s] = '0;
  endtask

  // One decision slot; the model follows the requirements R3..R11
  task automatic step(input bit v, input int p);
    int ts, d, idx;
    bit exp_err, exp_byp;
    logic [31:0] ok;
    ts = cyc / N;
    d = ((lastdep[p] > ts) ? lastdep[p] : ts) + 1;
    exp_byp = d < ts + ACC_SLOTS;
    ok = '0;
    for (int m = 0; m < K; m++)
      if (cyc - wlast[m] >= BUSY && !rtab[ts][m] && !rtab[d][m]) ok[m] = 1'b1;
    idx = -1;
    for (int m = K - 1; m >= 0; m--) if (ok[m]) idx = m;
    exp_err = (d - ts >= HORIZON) || (!exp_byp && idx < 0);
    req_valid = v;
    req_port = p[$clog2(N)-1:0];
    @(posedge clk);
    @(negedge clk);
    req_valid = 1'b0;
    chk(grant_valid == v, "R2 grant_valid", int'(grant_valid), int'(v));
    if (v) begin
      chk(grant_err == exp_err, "R10 grant_err", int'(grant_err), int'(exp_err));
      if (grant_err) errs_seen++;
      if (!exp_err) begin
        chk(int'(grant_dep) == d, "R4 grant_dep", int'(grant_dep), d);
        chk(grant_bypass == exp_byp, "R5 grant_bypass", int'(grant_bypass), int'(exp_byp));
        if (exp_byp) chk(grant_mem == 0, "R5 bypass mem", int'(grant_mem), 0);
        else chk(int'(grant_mem) == idx, "R9 lowest eligible mem", int'(grant_mem), idx);
        lastdep[p] = d;
        if (!exp_byp) begin
          wlast[idx] = cyc;
          rtab[d][idx] = 1'b1;
        end
      end
    end
    cyc++;
  endtask

  task automatic t_idle();
    do_reset();
    // R2: no request, no result; R3: slot reaches 1 after N idle cycles
    for (int i = 0; i < N + 1; i++) step(0, 0);
    // R5: idle output, departure = slot+1 -> bypass
    step(1, 2);
  endtask

  task automatic t_burst();
    do_reset();
    // R4 and R6: back-to-back cells to one output spread over memories
    for (int i = 0; i < 8; i++) step(1, 0);
  endtask

  task automatic t_mixed();
    do_reset();
    // R7 R8 R9: interleaved outputs with gaps
    for (int i = 0; i < 48; i++) step((i % 5) != 4, (i * 3) % N);
  endtask

  task automatic t_wrap();
    int pat [8] = '{0, 0, 1, 1, -1, 2, 3, -1};
    do_reset();
    // R11 and R12: steady backlog over several table wraps, no refusal
    errs_seen = 0;
    for (int i = 0; i < 240; i++) begin
      if (pat[i % 8] < 0) step(0, 0);
      else step(1, pat[i % 8]);
    end
    chk(errs_seen == 0, "R12 no refusal in steady traffic", errs_seen, 0);
  endtask

  task automatic t_overload();
    do_reset();
    errs_seen = 0;
    // R10: one output flooded until its backlog reaches the horizon
    for (int i = 0; i < 40; i++) step(1, 1);
    chk(errs_seen > 0, "R10 horizon refusal seen", errs_seen, 1);
    // R10: refused cells committed nothing; another output is unaffected
    step(1, 3);
  endtask

  initial begin
    fork
      begin
        t_idle();
        t_burst();
        t_mixed();
        t_wrap();
        t_overload();
      end
      begin
        repeat (20000) @(posedge clk);
        tests++; fails++;
        $display("FAIL watchdog actual=timeout expected=done");
      end
    join_any
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule